// File: doc/BRIEF.md
# Floppy Card Bus Glue

This block is the address decoding and control-latch logic of a floppy-controller expansion card on a host with a 16-bit address space. The host reaches it through two paths. The first is a single-bit control bus. A write there stores one bit into an eight-bit addressable latch. A read returns one bit picked from eight status sources. The second is a byte memory bus. The block decodes it into chip selects and local address bits for a banked boot ROM, a 2 KB buffer SRAM and the four registers of an external disk controller chip.

The latch drives the controller's master reset and density lines, the card's memory-window enable and the ROM bank. The block also keeps a registered record of which of four drives is selected and what side-select level that drive sees. Software enables the card through the control bus and then works in the memory window. To change drives it sets the new drive's bit before it clears the old one.

All decode outputs are combinational in the current address. Latch and drive-tracking state change on the rising clock edge that accepts a control-bus write.

Top module: `disk_card_glue`

## Requirements
- R1: After reset every latch bit is 0. card_en, ctl_reset, dden, side_out and drv_sel are all 0, and drv_num is 0 (no drive).
- R2: The control bus responds only when (cb_addr & 0xFF00) == 0x1100, and cb_addr[3:1] gives the bit number. A write with cb_wr_en outside that window changes nothing.
- R3: Latch bit 0 drives card_en, bit 1 drives ctl_reset, and bit 3 drives both dden and the ROM bank bit. Each takes effect from the clock edge that accepts the write.
- R4: A control-bus read of bit 0 returns ctl_irq, bit 1 returns ctl_drq, bit 2 returns turbo_sw and bit 3 returns 0. Outside the window cb_rd_hit and cb_rd_bit are 0.
- R5: Read bits 4..7 return the inverted step-rate switches in reversed order: bit 4 is ~step_sw[3] (drive 4) and bit 7 is ~step_sw[0] (drive 1). A switch at 0 (open) reads as 1.
- R6: Writing 1 to drive bit 4+k (k = 0..3) selects the lowest-numbered drive whose bit is set after the write. drv_num is then 1..4 and drv_sel has bit drv_num-1 set.
- R7: Writing 0 to a drive bit deselects (drv_num = 0) only when no drive bit remains set. Otherwise the current selection is kept unchanged.
- R8: When a drive becomes selected, side_out takes the latched side bit (latch bit 2). A later write to bit 2 updates side_out only if a drive is selected at that time.
- R9: ram_cs is 1 when mem_req, card_en and (mem_addr & 0xF800) == 0x5000 are all true. In that case ram_addr = mem_addr[10:0].
- R10: rom_cs is 1 when mem_req, card_en, mem_wr = 0 and (mem_addr & 0xF000) == 0x4000 are all true. In that case rom_addr = {bank, mem_addr[11:0]}. Writes never select the ROM.
- R11: ctl_cs is 1 when mem_req, card_en and (mem_addr & 0xFF01) == 0x5F01 are all true. In that case ctl_reg = mem_addr[2:1].
- R12: With card_en = 0 or mem_req = 0, rom_cs, ram_cs and ctl_cs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cb_addr | input | 16 | Control-bus address |
| cb_wr_en | input | 1 | Control-bus single-bit write strobe |
| cb_wr_bit | input | 1 | Bit value to write |
| cb_rd_hit | output | 1 | Control-bus address is in the card's window |
| cb_rd_bit | output | 1 | Control-bus read data bit |
| mem_addr | input | 16 | Memory-bus byte address |
| mem_req | input | 1 | Memory access in progress |
| mem_wr | input | 1 | Access is a write |
| rom_cs | output | 1 | Boot ROM select |
| rom_addr | output | 13 | ROM address (bank bit on top) |
| ram_cs | output | 1 | Buffer SRAM select |
| ram_addr | output | 11 | SRAM address |
| ctl_cs | output | 1 | Disk controller register select |
| ctl_reg | output | 2 | Controller register index |
| ctl_irq | input | 1 | Controller interrupt request |
| ctl_drq | input | 1 | Controller data request |
| turbo_sw | input | 1 | Turbo switch level |
| step_sw | input | 4 | Step-rate switches, bit k for drive k+1, 1 = closed |
| card_en | output | 1 | Memory window enabled |
| ctl_reset | output | 1 | Controller master reset |
| dden | output | 1 | Density select line |
| side_out | output | 1 | Side select to the selected drive |
| drv_sel | output | 4 | One-hot drive select |
| drv_num | output | 3 | Selected drive number, 0 = none |

## Verification
The memory decode is swept over a stride of addresses plus the edges of each region. Each address is tried with the card enabled and disabled and with reads and writes. This separates the three select windows from one another, shows that the card-enable gate works, and shows that writes are kept off the ROM. Drive tracking is driven through overlapping sequences of set-before-clear. These sequences tell lowest-wins priority apart from last-written-wins, and they tell the keep-on-partial-clear rule apart from immediate deselect. Side writes are made both with and without a drive selected. Status reads use a non-symmetric switch pattern, so the reversed bit order is visible.

// File: rtl/glue_pkg.sv
package glue_pkg;
  localparam int LATCH_W = 8;
  localparam int IDX_W   = $clog2(LATCH_W);

  typedef enum logic [IDX_W-1:0] {
    LB_CARD_EN = 3'd0,
    LB_CTL_RST = 3'd1,
    LB_SIDE    = 3'd2,
    LB_BANK    = 3'd3,
    LB_DRV0    = 3'd4
  } latch_bit_e;

  typedef enum logic [IDX_W-1:0] {
    RB_IRQ   = 3'd0,
    RB_DRQ   = 3'd1,
    RB_TURBO = 3'd2,
    RB_NC    = 3'd3
  } read_bit_e;
endpackage

// File: rtl/cb_latch.sv
module cb_latch
  import glue_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_MASK = 16'hFF00,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h1100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cb_addr,
  input  logic               cb_wr_en,
  input  logic               cb_wr_bit,
  output logic               win_hit,
  output logic [IDX_W-1:0]   bit_idx,
  output logic               wr_evt,
  output logic [LATCH_W-1:0] latch_q
);
  assign win_hit = (cb_addr & WIN_MASK) == WIN_BASE;
  assign bit_idx = cb_addr[IDX_W:1];
  assign wr_evt  = cb_wr_en && win_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)      latch_q <= '0;
    else if (wr_evt) latch_q[bit_idx] <= cb_wr_bit;
  end

  // R2
  latch_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_wr_en && win_hit) |=> latch_q[$past(bit_idx)] == $past(cb_wr_bit));
  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cb_wr_en && win_hit) |=> $stable(latch_q));
endmodule

// File: rtl/cb_readmux.sv
module cb_readmux
  import glue_pkg::*;
#(
  parameter int NUM_DRIVES = 4
) (
  input  logic                  win_hit,
  input  logic [IDX_W-1:0]      bit_idx,
  input  logic                  ctl_irq,
  input  logic                  ctl_drq,
  input  logic                  turbo_sw,
  input  logic [NUM_DRIVES-1:0] step_sw,
  output logic                  rd_bit
);
  localparam int SW_BASE = LATCH_W - NUM_DRIVES;
  logic [LATCH_W-1:0] rd_vec;

  assign rd_vec[RB_IRQ]   = ctl_irq;
  assign rd_vec[RB_DRQ]   = ctl_drq;
  assign rd_vec[RB_TURBO] = turbo_sw;
  assign rd_vec[RB_NC]    = 1'b0;

  for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_sw
    assign rd_vec[SW_BASE+g] = ~step_sw[NUM_DRIVES-1-g];
  end

  assign rd_bit = win_hit ? rd_vec[bit_idx] : 1'b0;
endmodule

// File: rtl/drive_tracker.sv
module drive_tracker
  import glue_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  parameter int DRV_BASE   = 4,
  localparam int DRV_W     = $clog2(NUM_DRIVES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_evt,
  input  logic [IDX_W-1:0]      bit_idx,
  input  logic                  wr_val,
  input  logic [NUM_DRIVES-1:0] drv_bits_q,
  input  logic                  side_q,
  output logic [DRV_W-1:0]      drv_num,
  output logic [NUM_DRIVES-1:0] drv_sel,
  output logic                  side_out
);
  logic [NUM_DRIVES-1:0] drv_bits_nx;
  logic [NUM_DRIVES-1:0] hit_vec;
  logic [DRV_W-1:0]      low_num;
  logic                  drive_wr;
  logic                  side_wr;

  for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_nx
    assign hit_vec[g]     = wr_evt && (bit_idx == IDX_W'(DRV_BASE + g));
    assign drv_bits_nx[g] = hit_vec[g] ? wr_val : drv_bits_q[g];
    assign drv_sel[g]     = drv_num == DRV_W'(g + 1);
  end

  assign drive_wr = |hit_vec;
  assign side_wr  = wr_evt && (bit_idx == LB_SIDE);

  always_comb begin
    low_num = '0;
    for (int i = NUM_DRIVES - 1; i >= 0; i--)
      if (drv_bits_nx[i]) low_num = DRV_W'(i + 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv_num  <= '0;
      side_out <= 1'b0;
    end else begin
      if (drive_wr && wr_val) begin
        drv_num  <= low_num;
        side_out <= side_q;
      end else if (drive_wr && !wr_val && drv_bits_nx == '0) begin
        drv_num <= '0;
      end
      if (side_wr && drv_num != '0) side_out <= wr_val;
    end
  end

  // R7
  no_orphan_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_num != '0) |-> (drv_bits_q != '0));
  // R6
  drv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |=> ($stable(drv_num) && $stable(side_out)));
  // R6
  drv_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_num <= DRV_W'(NUM_DRIVES));
endmodule

// File: rtl/mem_decode.sv
module mem_decode #(
  parameter int                ADDR_W      = 16,
  parameter int                RAM_AW      = 11,
  parameter int                ROM_PAGE_AW = 12,
  parameter int                REG_W       = 2,
  parameter logic [ADDR_W-1:0] ROM_BASE    = 16'h4000,
  parameter logic [ADDR_W-1:0] RAM_BASE    = 16'h5000,
  parameter logic [ADDR_W-1:0] CTL_MASK    = 16'hFF01,
  parameter logic [ADDR_W-1:0] CTL_BASE    = 16'h5F01
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    mem_addr,
  input  logic                 mem_req,
  input  logic                 mem_wr,
  input  logic                 card_en,
  input  logic                 bank,
  output logic                 rom_cs,
  output logic [ROM_PAGE_AW:0] rom_addr,
  output logic                 ram_cs,
  output logic [RAM_AW-1:0]    ram_addr,
  output logic                 ctl_cs,
  output logic [REG_W-1:0]     ctl_reg
);
  localparam logic [ADDR_W-1:0] ROM_MASK = ~ADDR_W'((1 << ROM_PAGE_AW) - 1);
  localparam logic [ADDR_W-1:0] RAM_MASK = ~ADDR_W'((1 << RAM_AW) - 1);

  logic gate;
  assign gate = mem_req && card_en;

  assign rom_cs = gate && !mem_wr && ((mem_addr & ROM_MASK) == ROM_BASE);
  assign ram_cs = gate && ((mem_addr & RAM_MASK) == RAM_BASE);
  assign ctl_cs = gate && ((mem_addr & CTL_MASK) == CTL_BASE);

  assign rom_addr = {bank, mem_addr[ROM_PAGE_AW-1:0]};
  assign ram_addr = mem_addr[RAM_AW-1:0];
  assign ctl_reg  = mem_addr[REG_W:1];

  // R9
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_cs, ram_cs, ctl_cs}));
  // R12
  sel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && card_en) |-> !(rom_cs || ram_cs || ctl_cs));
  // R10
  rom_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !rom_cs);
endmodule

// File: rtl/disk_card_glue.sv
module disk_card_glue
  import glue_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cb_addr,
  input  logic        cb_wr_en,
  input  logic        cb_wr_bit,
  output logic        cb_rd_hit,
  output logic        cb_rd_bit,
  input  logic [15:0] mem_addr,
  input  logic        mem_req,
  input  logic        mem_wr,
  output logic        rom_cs,
  output logic [12:0] rom_addr,
  output logic        ram_cs,
  output logic [10:0] ram_addr,
  output logic        ctl_cs,
  output logic [1:0]  ctl_reg,
  input  logic        ctl_irq,
  input  logic        ctl_drq,
  input  logic        turbo_sw,
  input  logic [3:0]  step_sw,
  output logic        card_en,
  output logic        ctl_reset,
  output logic        dden,
  output logic        side_out,
  output logic [3:0]  drv_sel,
  output logic [2:0]  drv_num
);
  localparam int NUM_DRIVES = 4;

  logic               win_hit;
  logic [IDX_W-1:0]   bit_idx;
  logic               wr_evt;
  logic [LATCH_W-1:0] latch_q;

  cb_latch u_latch (
    .clk(clk), .rst_n(rst_n), .cb_addr(cb_addr), .cb_wr_en(cb_wr_en),
    .cb_wr_bit(cb_wr_bit), .win_hit(win_hit), .bit_idx(bit_idx),
    .wr_evt(wr_evt), .latch_q(latch_q)
  );

  cb_readmux #(.NUM_DRIVES(NUM_DRIVES)) u_rdmux (
    .win_hit(win_hit), .bit_idx(bit_idx), .ctl_irq(ctl_irq),
    .ctl_drq(ctl_drq), .turbo_sw(turbo_sw), .step_sw(step_sw),
    .rd_bit(cb_rd_bit)
  );

  drive_tracker #(.NUM_DRIVES(NUM_DRIVES), .DRV_BASE(LB_DRV0)) u_track (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .bit_idx(bit_idx),
    .wr_val(cb_wr_bit), .drv_bits_q(latch_q[LB_DRV0 +: NUM_DRIVES]),
    .side_q(latch_q[LB_SIDE]), .drv_num(drv_num), .drv_sel(drv_sel),
    .side_out(side_out)
  );

  mem_decode u_dec (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_req(mem_req),
    .mem_wr(mem_wr), .card_en(card_en), .bank(latch_q[LB_BANK]),
    .rom_cs(rom_cs), .rom_addr(rom_addr), .ram_cs(ram_cs),
    .ram_addr(ram_addr), .ctl_cs(ctl_cs), .ctl_reg(ctl_reg)
  );

  assign cb_rd_hit = win_hit;
  assign card_en   = latch_q[LB_CARD_EN];
  assign ctl_reset = latch_q[LB_CTL_RST];
  assign dden      = latch_q[LB_BANK];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (latch_q == '0 && drv_num == '0 && !side_out));
endmodule

// File: tb/disk_card_glue_tb.sv
`timescale 1ns/1ps
module disk_card_glue_tb;
  logic clk = 0, rst_n = 0;
  logic [15:0] cb_addr = 0, mem_addr = 0;
  logic cb_wr_en = 0, cb_wr_bit = 0, mem_req = 0, mem_wr = 0;
  logic ctl_irq = 0, ctl_drq = 0, turbo_sw = 0;
  logic [3:0] step_sw = 0;
  logic cb_rd_hit, cb_rd_bit, rom_cs, ram_cs, ctl_cs;
  logic [12:0] rom_addr; logic [10:0] ram_addr; logic [1:0] ctl_reg;
  logic card_en, ctl_reset, dden, side_out;
  logic [3:0] drv_sel; logic [2:0] drv_num;

  always #2.5 clk = ~clk;

  disk_card_glue u_dut (.*);

  typedef struct { string req; int sel; logic [15:0] exp; } item_t;
  item_t sb[$];
  int total = 0, bad = 0;
  bit done = 0;

  function automatic logic [15:0] obs(int sel);
    case (sel)
      0: return {13'd0, rom_cs, ram_cs, ctl_cs};
      1: return {3'd0, rom_addr};
      2: return {5'd0, ram_addr};
      3: return {14'd0, ctl_reg};
      4: return {13'd0, drv_num};
      5: return {15'd0, side_out};
      6: return {15'd0, cb_rd_bit};
      7: return {13'd0, card_en, ctl_reset, dden};
      8: return {12'd0, drv_sel};
      default: return {15'd0, cb_rd_hit};
    endcase
  endfunction

  // monitor
  initial forever begin
    item_t it;
    wait (sb.size() > 0);
    it = sb.pop_front();
    total++;
    if (obs(it.sel) !== it.exp) begin
      bad++;
      $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, obs(it.sel), it.exp);
    end
  end

  task automatic expect_v(string req, int sel, logic [15:0] v);
    sb.push_back('{req, sel, v});
    wait (sb.size() == 0);
  endtask

  task automatic cb_wr(logic [15:0] a, logic b);
    @(negedge clk);
    cb_addr = a; cb_wr_bit = b; cb_wr_en = 1;
    @(negedge clk);
    cb_wr_en = 0;
  endtask

  task automatic lbit(int n, logic b);
    cb_wr(16'h1100 | 16'(n << 1), b);
  endtask

  function automatic logic [2:0] exp_cs(logic [15:0] a, logic en, logic rq, logic wr);
    logic g; g = en && rq;
    return {g && !wr && (a & 16'hF000) == 16'h4000,
            g && (a & 16'hF800) == 16'h5000,
            g && (a & 16'hFF01) == 16'h5F01};
  endfunction

  task automatic probe(logic [15:0] a, logic rq, logic wr, logic en, logic bank);
    logic [2:0] e;
    mem_addr = a; mem_req = rq; mem_wr = wr;
    #0.5;
    e = exp_cs(a, en, rq, wr);
    expect_v(en && rq ? "R9 R10 R11 select" : "R12 gated", 0, {13'd0, e});
    if (e[2]) expect_v("R10 rom addr", 1, {3'd0, bank, a[11:0]});
    if (e[1]) expect_v("R9 ram addr", 2, {5'd0, a[10:0]});
    if (e[0]) expect_v("R11 reg idx", 3, {14'd0, a[2:1]});
  endtask

  task automatic sweep(logic en, logic bank);
    logic [15:0] corners [12] = '{16'h3FFF, 16'h4000, 16'h4FFF, 16'h5000,
      16'h57FF, 16'h5800, 16'h5EFF, 16'h5F00, 16'h5F01, 16'h5F07, 16'h5F09, 16'h6000};
    for (int k = 0; k < 512; k++)
      for (int m = 0; m < 2; m++) probe(16'(k * 16'h0081), 1, m[0], en, bank);
    foreach (corners[i])
      for (int m = 0; m < 4; m++) probe(corners[i], m[1], m[0], en, bank);
  endtask

  initial begin
    #500us;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    expect_v("R1 latch outs", 7, 0);
    expect_v("R1 drv_num", 4, 0);
    expect_v("R1 drv_sel", 8, 0);
    expect_v("R1 side", 5, 0);
    // R12 disabled card sweep
    sweep(0, 0);
    // R2 write outside window ignored
    cb_wr(16'h1000, 1);
    cb_wr(16'h1200, 1);
    expect_v("R2 outside write ignored", 7, 0);
    // R3 latch bits
    lbit(0, 1); expect_v("R3 card_en", 7, 3'b100);
    lbit(1, 1); expect_v("R3 ctl_reset", 7, 3'b110);
    lbit(3, 1); expect_v("R3 dden/bank", 7, 3'b111);
    lbit(1, 0); expect_v("R3 ctl_reset clear", 7, 3'b101);
    sweep(1, 1);
    lbit(3, 0); expect_v("R3 dden clear", 7, 3'b100);
    sweep(1, 0);
    // R4 R5 reads
    ctl_irq = 1; ctl_drq = 0; turbo_sw = 1; step_sw = 4'b0101;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] ev;
      ev = {~step_sw[0], ~step_sw[1], ~step_sw[2], ~step_sw[3], 1'b0, turbo_sw, ctl_drq, ctl_irq};
      cb_addr = 16'h1100 | 16'(i << 1); #0.5;
      expect_v(i < 4 ? "R4 status bit" : "R5 switch bit", 6, {15'd0, ev[i]});
    end
    ctl_irq = 0; ctl_drq = 1; cb_addr = 16'h1102; #0.5;
    expect_v("R4 drq", 6, 1);
    cb_addr = 16'h1002; #0.5;
    expect_v("R4 outside hit", 9, 0);
    expect_v("R4 outside data", 6, 0);
    // R8 side while none selected
    lbit(2, 1); expect_v("R8 side ignored no drive", 5, 0);
    // R6 select drive 2, gets latched side
    lbit(5, 1); expect_v("R6 drv2", 4, 2); expect_v("R6 sel onehot", 8, 4'b0010);
    expect_v("R8 side on select", 5, 1);
    lbit(4, 1); expect_v("R6 lowest wins", 4, 1);
    lbit(4, 0); expect_v("R7 partial clear keeps", 4, 1);
    lbit(7, 1); expect_v("R6 lowest of 2,4", 4, 2);
    lbit(2, 0); expect_v("R8 side update while selected", 5, 0);
    lbit(5, 0); expect_v("R7 keep with drive4 set", 4, 2);
    lbit(7, 0); expect_v("R7 deselect all", 4, 0); expect_v("R7 sel none", 8, 0);
    lbit(2, 1); expect_v("R8 side held while none", 5, 0);
    lbit(6, 1); expect_v("R6 drv3", 4, 3); expect_v("R8 side latched", 5, 1);
    expect_v("R6 sel3", 8, 4'b0100);
    cb_wr(16'h1208, 1); expect_v("R2 foreign window no drive change", 4, 3);
    cb_wr(16'h1204, 0); expect_v("R2 foreign window no side change", 5, 1);
    // R1 reset again
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    expect_v("R1 reset drv", 4, 0);
    expect_v("R1 reset latch", 7, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule